// File: doc/BRIEF.md
# Fixed-Format FIFO UART Peripheral

This block is a compact serial port that hangs off a simple word-addressed register bus. Software pushes bytes into a 16-entry transmit queue and pops them from a 16-entry receive queue. Status flags, per-byte line error detection and one interrupt line complete the block. The bit rate (through a clock prescaler), the number of data bits and the parity mode are elaboration parameters, and no register can change them. The receiver cannot be switched off, so every valid frame on the line lands in the receive queue. Each queue is flushed only by reset or by its own control bit. A reset leaves the interrupt disabled.

The transmitter is a five-state machine. `TX_IDLE` moves to `TX_START` as soon as the queue holds a byte, and pops that byte on the same edge. `TX_START` moves to `TX_DATA` after one bit time. `TX_DATA` shifts the data bits out LSB first. After the last one it moves to `TX_PARITY` when parity is enabled, and to `TX_STOP` otherwise. `TX_PARITY` moves to `TX_STOP`, and `TX_STOP` returns to `TX_IDLE`. One bit time is 16 prescaler ticks.

The receiver mirrors this with `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PARITY` and `RX_STOP`. `RX_IDLE` moves to `RX_START` on a low sample. `RX_START` checks the line again eight ticks later. It goes to `RX_DATA` if the line is still low, and back to `RX_IDLE` if it has gone high. `RX_DATA` samples each data bit at its centre. It then goes to `RX_PARITY` or `RX_STOP`, as the transmitter does. `RX_STOP` samples the stop bit, delivers the byte and returns to `RX_IDLE`.

Top module: `uart_fifo_periph`

## Requirements
- R1: After reset, the status word (word offset 0x8) reads 0x04. Its bits are: bit0 receive data valid, bit1 receive queue full, bit2 transmit queue empty, bit3 transmit queue full, bit4 interrupt enabled, bit5 overrun, bit6 framing error, bit7 parity error. After reset `irq` is low and `uart_tx` is high.
- R2: Each transmitted frame has a low start bit, then the data bits LSB first, then an even parity bit (with the default parity settings), then a high stop bit. Each bit lasts 16*CLKS_PER_TICK clocks.
- R3: A byte written at offset 0x4 is sent, and a correctly framed byte that arrives on `uart_rx` is stored. Reads at offset 0x0 return the stored bytes in arrival order, and each read pops one byte. A read from an empty queue returns 0.
- R4: Each queue holds 16 bytes. A write to a full transmit queue is dropped, and status bit3 shows the full condition.
- R5: A byte that completes while the receive queue is full is discarded, and overrun (bit5) is set. Status bit1 shows the full condition.
- R6: A parity mismatch sets bit7, and the byte is still stored.
- R7: A stop bit sampled low sets bit6, and the byte is still stored.
- R8: Reading the status word clears bits 5 to 7. The read returns their values from before the clear.
- R9: Writing the control word (offset 0xC) with bit0 set empties the transmit queue. A frame already on the line still completes.
- R10: Writing the control word with bit1 set empties the receive queue.
- R11: Control bit4 is the interrupt enable, and every control write loads it. Status bit4 reads back its value. While it is clear, `irq` is low.
- R12: With the interrupt enabled and the receive queue empty, `irq` is high for exactly one cycle when the transmit queue goes from holding data to empty.
- R13: With the interrupt enabled, `irq` stays high while the receive queue holds data. It drops within 3 cycles of the read that empties the queue.
- R14: The receiver is always active. It stores frames even while the interrupt is disabled, and it rejects a low pulse shorter than half a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| irq | output | 1 | Interrupt request |
| uart_rx | input | 1 | Serial input, idle high |
| uart_tx | output | 1 | Serial output, idle high |

## Verification
Read data is registered, so the bench samples `bus_rdata` one edge after the strobe. A pop or status clear takes effect on that same edge. Receive results exist only after the receiver samples the stop bit at mid-bit, roughly 10.5 bit times after the start edge plus two synchronizer clocks. The bench therefore waits at least one full frame plus a bit of idle before it reads. The transmit-empty interrupt appears two edges after the write: one edge for the pop and one for the registered `irq`. The bench counts high cycles of `irq` over a window instead of sampling a single edge. It also decodes `uart_tx` at mid-bit, so drift between the prescaler phase and the start edge cannot shift its samples.

// File: rtl/uartp_pkg.sv
package uartp_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    // word index = bus_addr[3:2]
    localparam logic [1:0] WRD_RXDATA = 2'd0;
    localparam logic [1:0] WRD_TXDATA = 2'd1;
    localparam logic [1:0] WRD_STATUS = 2'd2;
    localparam logic [1:0] WRD_CTRL   = 2'd3;

    localparam int CTL_TXFLUSH = 0;
    localparam int CTL_RXFLUSH = 1;
    localparam int CTL_IEN     = 4;

    localparam int TICKS_PER_BIT = 16;
    localparam int MID_TICK      = 7;
endpackage

// File: rtl/uartp_fifo.sv
module uartp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic                           empty,
    output logic                           full,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uartp_tx.sv
module uartp_tx
    import uartp_pkg::*;
#(
    parameter int DW         = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_pop,
    output logic          tx_o
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_t     state, nxt;
    logic [3:0]    tcnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          bit_end;
    logic          last_data;

    assign bit_end   = tick && (tcnt == 4'(TICKS_PER_BIT-1));
    assign last_data = (idx == IW'(DW-1));

    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (!fifo_empty) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && last_data) nxt = PARITY_EN ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (bit_end) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else if (state == TX_IDLE) begin
            tcnt <= '0;
            idx  <= '0;
            if (!fifo_empty) begin
                sh   <= fifo_data;
                pbit <= (^fifo_data) ^ PARITY_ODD;
            end
        end else begin
            if (tick) tcnt <= tcnt + 1'b1;
            if (state == TX_DATA && bit_end) begin
                sh  <= sh >> 1;
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        fifo_pop = (state == TX_IDLE) && !fifo_empty;
        unique case (state)
            TX_IDLE:   tx_o = 1'b1;
            TX_START:  tx_o = 1'b0;
            TX_DATA:   tx_o = sh[0];
            TX_PARITY: tx_o = pbit;
            TX_STOP:   tx_o = 1'b1;
            default:   tx_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/uartp_rx.sv
module uartp_rx
    import uartp_pkg::*;
#(
    parameter int DW         = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rx_i,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          frame_err,
    output logic          par_err
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    rx_state_t     state, nxt;
    logic [1:0]    sync;
    logic          rx_s;
    logic [3:0]    tcnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] sh;
    logic          pbit;
    logic          bit_mid;
    logic          start_mid;
    logic          last_data;
    logic          par_bad;

    assign rx_s      = sync[1];
    assign bit_mid   = tick && (tcnt == 4'(TICKS_PER_BIT-1));
    assign start_mid = tick && (tcnt == 4'(MID_TICK));
    assign last_data = (idx == IW'(DW-1));

    generate
        if (PARITY_EN) begin : g_par
            assign par_bad = pbit ^ (^sh) ^ PARITY_ODD;
        end else begin : g_nopar
            assign par_bad = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rx_i};
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RX_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rx_s) nxt = RX_START;
            RX_START:  if (start_mid) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_mid && last_data) nxt = PARITY_EN ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_mid) nxt = RX_STOP;
            RX_STOP:   if (bit_mid) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            idx  <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    tcnt <= '0;
                    idx  <= '0;
                end
                RX_START: begin
                    if (start_mid)  tcnt <= '0;
                    else if (tick)  tcnt <= tcnt + 1'b1;
                end
                RX_DATA: begin
                    if (tick) tcnt <= tcnt + 1'b1;
                    if (bit_mid) begin
                        sh  <= {rx_s, sh[DW-1:1]};
                        idx <= idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) tcnt <= tcnt + 1'b1;
                    if (bit_mid) pbit <= rx_s;
                end
                RX_STOP: begin
                    if (tick) tcnt <= tcnt + 1'b1;
                end
                default: tcnt <= '0;
            endcase
        end
    end

    always_comb begin
        done      = (state == RX_STOP) && bit_mid;
        data      = sh;
        frame_err = done && !rx_s;
        par_err   = done && par_bad;
    end
endmodule

// File: rtl/uart_fifo_periph.sv
module uart_fifo_periph
    import uartp_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int DW            = 8,
    parameter bit PARITY_EN     = 1'b1,
    parameter bit PARITY_ODD    = 1'b0,
    parameter int FIFO_DEPTH    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        uart_rx,
    output logic        uart_tx
);
    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam int CW = $clog2(FIFO_DEPTH+1);

    logic [PW-1:0] pre;
    logic          tick;

    always_ff @(posedge clk) begin
        if (rst || pre == PW'(CLKS_PER_TICK-1)) pre <= '0;
        else                                    pre <= pre + 1'b1;
    end
    assign tick = (pre == PW'(CLKS_PER_TICK-1));

    logic [1:0] wsel;
    logic       wr_tx, wr_ctl, rd_rx, rd_st;
    assign wsel   = bus_addr[3:2];
    assign wr_tx  = bus_en &&  bus_we && wsel == WRD_TXDATA;
    assign wr_ctl = bus_en &&  bus_we && wsel == WRD_CTRL;
    assign rd_rx  = bus_en && !bus_we && wsel == WRD_RXDATA;
    assign rd_st  = bus_en && !bus_we && wsel == WRD_STATUS;

    logic          tx_clr, rx_clr;
    assign tx_clr = wr_ctl && bus_wdata[CTL_TXFLUSH];
    assign rx_clr = wr_ctl && bus_wdata[CTL_RXFLUSH];

    logic          tx_pop, tx_empty, tx_full;
    logic [DW-1:0] tx_head;
    logic [CW-1:0] tx_count;

    uartp_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(wr_tx), .din(bus_wdata[DW-1:0]),
        .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_count)
    );

    uartp_tx #(.DW(DW), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
        .clk(clk), .rst(rst), .tick(tick),
        .fifo_empty(tx_empty), .fifo_data(tx_head),
        .fifo_pop(tx_pop), .tx_o(uart_tx)
    );

    logic          rx_done, rx_ferr, rx_perr;
    logic [DW-1:0] rx_byte;

    uartp_rx #(.DW(DW), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rx_i(uart_rx),
        .done(rx_done), .data(rx_byte),
        .frame_err(rx_ferr), .par_err(rx_perr)
    );

    logic          rx_empty, rx_full;
    logic [DW-1:0] rx_head;
    logic [CW-1:0] rx_count;

    uartp_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_done), .din(rx_byte),
        .pop(rd_rx), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    logic ctl_ien, err_ovr, err_frm, err_par, tx_empty_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_ien <= 1'b0;
            err_ovr <= 1'b0;
            err_frm <= 1'b0;
            err_par <= 1'b0;
        end else begin
            if (wr_ctl) ctl_ien <= bus_wdata[CTL_IEN];
            err_ovr <= (err_ovr && !rd_st) || (rx_done && rx_full);
            err_frm <= (err_frm && !rd_st) || rx_ferr;
            err_par <= (err_par && !rd_st) || rx_perr;
        end
    end

    logic [7:0] status;
    assign status = {err_par, err_frm, err_ovr, ctl_ien,
                     tx_full, tx_empty, rx_full, !rx_empty};

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            unique case (wsel)
                WRD_RXDATA: bus_rdata <= rx_empty ? '0 : 32'(rx_head);
                WRD_STATUS: bus_rdata <= 32'(status);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_empty_d <= 1'b1;
            irq        <= 1'b0;
        end else begin
            tx_empty_d <= tx_empty;
            irq        <= ctl_ien && ((tx_empty && !tx_empty_d) || !rx_empty);
        end
    end
endmodule

// File: rtl/uartp_checker.sv
module uartp_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ien,
    input logic          irq,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          ovr,
    input logic          rx_done,
    input logic          rx_full,
    input logic          rx_clr,
    input logic          rd_rx,
    input logic          ctl_wr,
    input logic          ctl_ien_bit
);
    // R11
    ien_off_irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ien |=> !irq);

    // R11
    ctl_loads_ien_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ien == $past(ctl_ien_bit)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    // R5
    ovr_source_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !$past(ovr)) |-> $past(rx_done && rx_full));

    // R3
    rx_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && !rd_rx && !rx_clr) |=> $stable(rx_count));
endmodule

bind uart_fifo_periph uartp_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ien(ctl_ien), .irq(irq),
    .tx_count(tx_count), .rx_count(rx_count), .ovr(err_ovr),
    .rx_done(rx_done), .rx_full(rx_full), .rx_clr(rx_clr),
    .rd_rx(rd_rx), .ctl_wr(wr_ctl), .ctl_ien_bit(bus_wdata[4])
);

// File: tb/uart_fifo_periph_test.sv
`timescale 1ns/1ps
module uart_fifo_periph_test;
    localparam int CPT   = 2;
    localparam int BIT   = 16*CPT;
    localparam int FRAME = 11*BIT;
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_w, rx_w;
    logic        loop = 1'b0, drv = 1'b1;

    always #4 clk = ~clk;
    assign rx_w = loop ? tx_w : drv;

    uart_fifo_periph #(.CLKS_PER_TICK(CPT)) uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .uart_rx(rx_w), .uart_tx(tx_w)
    );

    int tests = 0, fails = 0, cyc = 0;
    int mon_cnt = 0;
    logic [7:0] mon_buf [256];
    int irq_hi = 0;
    logic irq_mon = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) if (irq_mon && irq) irq_hi++;

    // R2: frame decoder on uart_tx
    always begin
        logic [7:0] b;
        logic st, p, s;
        @(negedge tx_w);
        repeat (BIT/2) @(posedge clk);
        st = tx_w;
        for (int k = 0; k < 8; k++) begin
            repeat (BIT) @(posedge clk);
            b[k] = tx_w;
        end
        repeat (BIT) @(posedge clk); p = tx_w;
        repeat (BIT) @(posedge clk); s = tx_w;
        mon_buf[mon_cnt % 256] = b;
        mon_cnt++;
        chk("R2 tx frame start/parity/stop", {29'd0, st, p, s}, {29'd0, 1'b0, ^b, 1'b1});
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        drv = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            drv = b[k];
            repeat (BIT) @(negedge clk);
        end
        drv = (^b) ^ bad_par;
        repeat (BIT) @(negedge clk);
        if (bad_stop) begin
            drv = 1'b0;
            repeat (10*CPT) @(negedge clk);
        end
        drv = 1'b1;
        repeat (2*BIT) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd(4'h8, d);
        chk("R1 status after reset", d, 32'h04);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 tx idle high", {31'd0, tx_w}, 32'd1);
        rd(4'h0, d);
        chk("R3 read of empty rx queue", d, 32'd0);

        // R3, R2: loopback sweep of 64 byte values in blocks of 8
        loop = 1'b1;
        for (int blk = 0; blk < 8; blk++) begin
            for (int i = 0; i < 8; i++) wr(4'h4, 32'((((blk*8+i)*37)+5) & 255));
            repeat (9*FRAME) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                rd(4'h0, d);
                chk("R3 loopback byte", d, 32'((((blk*8+i)*37)+5) & 255));
            end
        end
        rd(4'h8, d);
        chk("R3 rx queue drained", d & 32'h01, 32'h0);

        // R4, R5, R8: 18 back-to-back writes
        base = mon_cnt;
        for (int i = 0; i < 18; i++) wr(4'h4, 32'(8'hA0 + i));
        rd(4'h8, d);
        chk("R4 tx queue full flag", d & 32'h08, 32'h08);
        repeat (19*FRAME) @(negedge clk);
        chk("R4 frames sent after overfill", 32'(mon_cnt - base), 32'd17);
        rd(4'h8, d);
        chk("R5 full + overrun status", d, 32'h27);
        rd(4'h8, d);
        chk("R8 errors cleared by status read", d, 32'h07);
        for (int i = 0; i < 16; i++) begin
            rd(4'h0, d);
            chk("R5 stored order after overrun", d, 32'(8'hA0 + i));
        end
        rd(4'h8, d);
        chk("R5 overrun byte discarded", d & 32'h01, 32'h0);
        loop = 1'b0;

        // R6: parity error
        send(8'h5A, 1'b1, 1'b0);
        rd(4'h8, d);
        chk("R6 parity error status", d, 32'h85);
        rd(4'h0, d);
        chk("R6 byte kept on parity error", d, 32'h5A);

        // R7: framing error
        send(8'hC3, 1'b0, 1'b1);
        rd(4'h8, d);
        chk("R7 framing error status", d, 32'h45);
        rd(4'h0, d);
        chk("R7 byte kept on framing error", d, 32'hC3);
        rd(4'h8, d);
        chk("R8 error bits read-cleared", d, 32'h04);

        // R14: glitch rejection
        drv = 1'b0;
        repeat (4*CPT) @(negedge clk);
        drv = 1'b1;
        repeat (2*FRAME) @(negedge clk);
        rd(4'h8, d);
        chk("R14 short low pulse rejected", d & 32'h01, 32'h0);

        // R10: rx flush
        send(8'h11, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0);
        rd(4'h8, d);
        chk("R14 receiver active with irq disabled", d & 32'h01, 32'h01);
        wr(4'hC, 32'h02);
        rd(4'h8, d);
        chk("R10 rx flush", d & 32'h03, 32'h0);
        rd(4'h0, d);
        chk("R10 rx data after flush", d, 32'h0);

        // R9: tx flush keeps the frame in flight
        base = mon_cnt;
        for (int i = 0; i < 5; i++) wr(4'h4, 32'(8'h30 + i));
        wr(4'hC, 32'h01);
        rd(4'h8, d);
        chk("R9 tx empty after flush", d & 32'h0C, 32'h04);
        repeat (4*FRAME) @(negedge clk);
        chk("R9 only in-flight frame sent", 32'(mon_cnt - base), 32'd1);
        chk("R9 in-flight byte value", 32'(mon_buf[base % 256]), 32'h30);

        // R11, R12: interrupt on tx drain
        wr(4'hC, 32'h10);
        rd(4'h8, d);
        chk("R11 enable readback", d & 32'h10, 32'h10);
        repeat (3) @(negedge clk);
        chk("R12 no irq while idle", {31'd0, irq}, 32'd0);
        irq_hi = 0;
        irq_mon = 1'b1;
        wr(4'h4, 32'h55);
        repeat (40) @(negedge clk);
        irq_mon = 1'b0;
        chk("R12 one-cycle tx empty pulse", 32'(irq_hi), 32'd1);
        repeat (FRAME) @(negedge clk);

        // R13: level irq while rx holds data
        send(8'h3C, 1'b0, 1'b0);
        chk("R13 irq with rx data", {31'd0, irq}, 32'd1);
        rd(4'h0, d);
        chk("R13 rx byte", d, 32'h3C);
        repeat (3) @(negedge clk);
        chk("R13 irq drops after drain", {31'd0, irq}, 32'd0);

        // R11: disabled interrupt stays low with data present
        wr(4'hC, 32'h00);
        send(8'h77, 1'b0, 1'b0);
        chk("R11 irq low when disabled", {31'd0, irq}, 32'd0);
        rd(4'h8, d);
        chk("R11 status with data, irq off", d, 32'h05);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule